// File: doc/BRIEF.md
# Channel Control Register with Interlocked, Clock-Crossed Enable

This block holds the control word for one peripheral channel. Software writes it through a one-cycle write strobe in the bus clock domain and reads it back at any time. One bit of the word is the channel enable. The other implemented bits are configuration fields used by the functional logic, which runs on a separate and slower clock.

A change to the enable is not applied at once. It is sent to the functional clock domain as a toggle request through a two-flop synchronizer. The functional side flips its enable and returns the toggle as an acknowledgement through a second two-flop synchronizer. Until that acknowledgement arrives, the block raises a busy flag, the readback still shows the old enable, and every new write is dropped.

The configuration fields can be written only while the enable reads back as zero and no handshake is in flight. After an enable has been set, the fields stay frozen until a later disable has fully completed. A write that sets the enable and also changes fields takes both, because the lock only begins once the enable has been set.

Top module: `chan_cfg_lock`

## Requirements
- R1: After reset, `rd_data` is all zeros, `sync_busy` is 0 and `f_enable` is 0.
- R2: With the default mask, bit 0 is the enable, bits 1 to 23 are writable configuration bits, and bits 24 to 31 always read zero.
- R3: While the readback enable is 1, a write leaves bits 1 and up unchanged.
- R4: A write accepted while not busy, whose bit 0 differs from the readback enable, sets `sync_busy` at the next clock edge. `sync_busy` stays high until the acknowledgement from the functional domain has been synchronized back.
- R5: While `sync_busy` is high, `rd_data[0]` keeps the previous enable value. It takes the requested value on the same edge at which `sync_busy` falls.
- R6: `f_enable` changes only after the request has been held across at least two functional-clock edges. By the time `sync_busy` falls, `f_enable` equals the requested value.
- R7: Every write made while `sync_busy` is high is ignored completely, including any write that lands in the cycle the acknowledgement arrives.
- R8: A single write that sets the enable from 0 also stores its configuration bits.
- R9: A write whose bit 0 equals the current readback enable starts no handshake, so `sync_busy` stays 0.
- R10: `f_cfg` always equals the configuration bits shown in `rd_data`, with bit 0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain asynchronous reset, active low |
| fclk | input | 1 | Functional clock |
| frst_n | input | 1 | Functional-domain asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| wr_data | input | REG_W | Write value; bit 0 is the enable |
| rd_data | output | REG_W | Readback of configuration bits and the synchronized enable |
| sync_busy | output | 1 | High while an enable change is crossing domains |
| f_enable | output | 1 | Enable in the functional clock domain |
| f_cfg | output | REG_W | Configuration bits for the functional logic, bit 0 zero |

## Verification
Two events can fall on the same bus edge: a software write arrives, and the returning acknowledgement completes a pending enable change. To provoke this, the bench issues a write on every bus cycle from the moment an enable change starts until `sync_busy` drops. One of those writes is therefore certain to meet the acknowledgement edge. After the flag falls, the bench requires the fields to be untouched and the enable to equal the originally requested value, so none of the flood writes may have slipped through.

// File: rtl/chan_cfg_pkg.sv
`timescale 1ns/1ps
package chan_cfg_pkg;

    localparam int unsigned SYNC_STAGES = 2;

    // Bus-domain register image
    typedef struct packed {
        logic [63:0] cfg;       // configuration bits, sized for the widest use
        logic        en;        // enable as seen by software
        logic        pend;      // enable value being requested
        logic        busy;      // handshake in flight
        logic        req_tgl;   // request toggle towards functional domain
        logic        ack_seen;  // last acknowledgement toggle consumed
    } bus_state_t;

    // Functional-domain state
    typedef struct packed {
        logic en;        // applied enable
        logic seen_tgl;  // last request toggle consumed, doubles as ack
    } func_state_t;

endpackage

// File: rtl/cfg_sync_chain.sv
`timescale 1ns/1ps
module cfg_sync_chain #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_func_side.sv
`timescale 1ns/1ps
module cfg_func_side
    import chan_cfg_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic fclk,
    input  logic frst_n,
    input  logic req_tgl,
    output logic ack_tgl,
    output logic f_enable
);
    logic        req_s;
    func_state_t st_d, st_q;

    cfg_sync_chain #(.STAGES(STAGES)) u_req_sync (
        .clk   (fclk),
        .rst_n (frst_n),
        .d     (req_tgl),
        .q     (req_s)
    );

    always_comb begin
        st_d = st_q;
        if (req_s != st_q.seen_tgl) begin
            st_d.seen_tgl = req_s;
            st_d.en       = ~st_q.en;
        end
    end

    always_ff @(posedge fclk or negedge frst_n) begin
        if (!frst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ack_tgl  = st_q.seen_tgl;
    assign f_enable = st_q.en;
endmodule

// File: rtl/cfg_bus_side.sv
`timescale 1ns/1ps
module cfg_bus_side
    import chan_cfg_pkg::*;
#(
    parameter int unsigned REG_W    = 32,
    parameter logic [REG_W-1:0] CFG_MASK = 32'h00FF_FFFE,
    parameter int unsigned STAGES   = SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             ack_tgl,
    output logic             req_tgl,
    output logic             busy,
    output logic             en,
    output logic [REG_W-1:0] cfg
);
    localparam logic [REG_W-1:0] FIELD_MASK = CFG_MASK & ~REG_W'(1);

    logic       ack_s;
    logic       ack_edge;
    bus_state_t st_d, st_q;

    cfg_sync_chain #(.STAGES(STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_tgl),
        .q     (ack_s)
    );

    assign ack_edge = (ack_s != st_q.ack_seen);

    always_comb begin
        st_d = st_q;
        // completion of a pending enable change
        if (ack_edge) begin
            st_d.ack_seen = ack_s;
            st_d.busy     = 1'b0;
            st_d.en       = st_q.pend;
        end
        // writes are accepted only when no handshake is in flight
        if (wr_en && !st_q.busy) begin
            if (!st_q.en) begin
                st_d.cfg = '0;
                st_d.cfg[REG_W-1:0] = wr_data & FIELD_MASK;
            end
            if (wr_data[0] != st_q.en) begin
                st_d.busy    = 1'b1;
                st_d.pend    = wr_data[0];
                st_d.req_tgl = ~st_q.req_tgl;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_tgl = st_q.req_tgl;
    assign busy    = st_q.busy;
    assign en      = st_q.en;
    assign cfg     = st_q.cfg[REG_W-1:0];
endmodule

// File: rtl/chan_cfg_lock.sv
`timescale 1ns/1ps
module chan_cfg_lock
    import chan_cfg_pkg::*;
#(
    parameter int unsigned      REG_W    = 32,
    parameter logic [REG_W-1:0] CFG_MASK = 32'h00FF_FFFE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fclk,
    input  logic             frst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             sync_busy,
    output logic             f_enable,
    output logic [REG_W-1:0] f_cfg
);
    logic             req_tgl;
    logic             ack_tgl;
    logic             en_rb;
    logic [REG_W-1:0] cfg_bits;

    cfg_bus_side #(
        .REG_W    (REG_W),
        .CFG_MASK (CFG_MASK),
        .STAGES   (SYNC_STAGES)
    ) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ack_tgl (ack_tgl),
        .req_tgl (req_tgl),
        .busy    (sync_busy),
        .en      (en_rb),
        .cfg     (cfg_bits)
    );

    cfg_func_side #(
        .STAGES (SYNC_STAGES)
    ) u_func (
        .fclk     (fclk),
        .frst_n   (frst_n),
        .req_tgl  (req_tgl),
        .ack_tgl  (ack_tgl),
        .f_enable (f_enable)
    );

    assign rd_data = {cfg_bits[REG_W-1:1], en_rb};
    assign f_cfg   = {cfg_bits[REG_W-1:1], 1'b0};
endmodule

// File: rtl/chan_cfg_lock_chk.sv
`timescale 1ns/1ps
module chan_cfg_lock_chk #(
    parameter int unsigned      REG_W    = 32,
    parameter logic [REG_W-1:0] CFG_MASK = 32'h00FF_FFFE
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fclk,
    input logic             frst_n,
    input logic [REG_W-1:0] rd_data,
    input logic             sync_busy,
    input logic             f_enable
);
    localparam logic [REG_W-1:0] ZERO_BITS = ~(CFG_MASK | REG_W'(1));

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ZERO_BITS) == '0);  // R2

    AST_LOCK_WHEN_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_data[0]) |-> $stable(rd_data[REG_W-1:1]));  // R3

    AST_EN_MOVES_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(rd_data[0]) |-> $fell(sync_busy));  // R5

    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sync_busy) |-> $stable(rd_data[REG_W-1:1]));  // R7

    AST_FEN_LATENCY: assert property (@(posedge fclk) disable iff (!frst_n || !rst_n)
        $changed(f_enable) |-> ($past(sync_busy, 1) && $past(sync_busy, 2)));  // R6
endmodule

bind chan_cfg_lock chan_cfg_lock_chk #(
    .REG_W    (REG_W),
    .CFG_MASK (CFG_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fclk      (fclk),
    .frst_n    (frst_n),
    .rd_data   (rd_data),
    .sync_busy (sync_busy),
    .f_enable  (f_enable)
);

// File: tb/tb_chan_cfg_lock.sv
`timescale 1ns/1ps
module tb_chan_cfg_lock;
    localparam int          W    = 32;
    localparam logic [31:0] MASK = 32'h00FF_FFFE;

    logic          clk = 1'b0, fclk = 1'b0;
    logic          rst_n = 1'b0, frst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  rd_data, f_cfg;
    logic          sync_busy, f_enable;

    int checks = 0, errors = 0;
    logic [W-1:0] m_cfg = '0;
    logic         m_en  = 1'b0;
    bit           done  = 1'b0;

    always #2 clk = ~clk;               // 250 MHz
    initial begin #0.5; forever #5 fclk = ~fclk; end

    chan_cfg_lock dut (
        .clk(clk), .rst_n(rst_n), .fclk(fclk), .frst_n(frst_n),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .sync_busy(sync_busy), .f_enable(f_enable), .f_cfg(f_cfg)
    );

    function automatic logic [W-1:0] exp_rd();
        return m_cfg | W'(m_en);
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at a falling edge, return at the next falling edge
    task automatic do_write(input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (sync_busy && n < 200) begin @(negedge clk); n++; end
        checks++;
        if (sync_busy) begin errors++; $display("FAIL R4 busy stuck actual=1 expected=0"); end
    endtask

    // write when idle, model the result, check the whole exchange
    task automatic idle_write(input logic [W-1:0] d);
        logic old_en = m_en;
        logic chg    = (d[0] != m_en);
        if (!m_en) m_cfg = d & MASK & ~W'(1);   // R8 / R2
        do_write(d);
        chk("R4 busy after write", W'(sync_busy), W'(chg));
        chk("R5 old enable while busy", rd_data, m_cfg | W'(old_en));
        chk("R6 f_enable not yet moved", W'(f_enable), W'(old_en));
        if (chg) begin
            m_en = d[0];
            wait_idle();
        end else begin
            chk("R9 no handshake", W'(sync_busy), '0);
        end
        chk("R3 readback", rd_data, exp_rd());
        chk("R6 f_enable applied", W'(f_enable), W'(m_en));
        chk("R10 f_cfg mirror", f_cfg, m_cfg);
    endtask

    initial begin
        #40000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1; frst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset rd_data", rd_data, '0);
        chk("R1 reset busy", W'(sync_busy), '0);
        chk("R1 reset f_enable", W'(f_enable), '0);

        // R2: upper bits read zero; fields written while disabled
        idle_write(32'hFFFF_FFFE);
        // R9: same enable value, no handshake
        idle_write(32'h0012_3450);
        // R8: enable plus new fields in one write
        idle_write(32'h00AB_CDE1);
        // R3: fields locked while enabled; R9 rewrite of enable=1
        idle_write(32'h0055_5555);
        idle_write(32'h0000_0000);   // disable; fields still locked
        idle_write(32'h0077_0010);   // now free again

        // R7: flood writes during the whole handshake, one meets the ack edge
        begin
            logic old_en = m_en;
            m_cfg = 32'h0011_2200;
            do_write(32'h0011_2201);
            m_en = 1'b1;
            while (sync_busy) begin
                chk("R7 flood ignored", rd_data, m_cfg | W'(old_en));
                wr_en = 1'b1; wr_data = $urandom & ~32'h1;
                @(negedge clk);
            end
            wr_en = 1'b0;
            chk("R7 after flood", rd_data, exp_rd());
            chk("R7 f_enable", W'(f_enable), 1);
            @(negedge clk);
            chk("R7 no late handshake", W'(sync_busy), '0);
        end

        // random mix
        for (int i = 0; i < 150; i++) begin
            logic [W-1:0] d = $urandom;
            if (($urandom % 3) != 0) d[0] = m_en;
            idle_write(d);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule